// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block chooses the source of a supervised output rail: the main supply, or a backup battery when the main supply sags. It works on digital flags from external comparators and registers every decision on the system clock. It drives a supply-select line for the power switch and a matching on-battery flag.

The block has two protection features. A manual input can force the rail onto the battery. A freshness seal keeps the battery isolated until the product is first used. The seal is armed by holding the power-fail and manual-reset levels low while the main supply powers down. It is released by the first rising edge of the system reset once power returns.

After reset is released, the block also runs periodic battery checks. Each check opens a short measurement window and latches the battery comparator's verdict on the window's last cycle. The battery-OK flag keeps that verdict until the next check.

Top module: `supply_switchover`

## Requirements
- R1: While `rstAsyncN` is low, and right after it rises, `selBattery` and `battOn` are 0, `measEn` is 0 and `battOk` is 1.
- R2: When the rail is on the main supply, there is no seal and `manSwitch` is 0, the battery is selected on the next clock only if `outBelowSwn` is 1 and `mainAboveBat` is 0.
- R3: When the rail is on the battery, there is no seal and `manSwitch` is 0, the rail returns to the main supply on the next clock as soon as either `mainAboveBat` or `mainAboveSwp` is 1.
- R4: `manSwitch` = 1 selects the battery on the next clock unless the seal is active.
- R5: `selBattery` encodes the source (1 = battery, 0 = main). `battOn` always equals `selBattery`.
- R6: The seal arms on a clock edge where `mainAboveSw` was 1 on the previous edge and is now 0, while `pfoLvl` and `mrLvl` are both 0.
- R7: While the seal is active the battery is never selected, whatever the other inputs are. The seal is cleared only by the power-on clear or by a rising edge of `resetLvl`.
- R8: After `resetLvl` is sampled high, `measEn` is high for `MEAS_CYC` cycles at the start of every `PERIOD_CYC`-cycle period. The first window begins on the following cycle. `measEn` stays 0 while `resetLvl` is low.
- R9: `battOk` takes the value of `batAboveOk` sampled on the last cycle of each measurement window. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstAsyncN | input | 1 | Asynchronous power-on clear, active low |
| mainAboveSw | input | 1 | Main supply above the switch threshold |
| mainAboveBat | input | 1 | Main supply above the battery voltage |
| outBelowSwn | input | 1 | Output rail below the negative switch threshold |
| mainAboveSwp | input | 1 | Main supply above the positive switch threshold |
| batAboveOk | input | 1 | Battery above the OK threshold |
| manSwitch | input | 1 | Manual request for battery operation |
| resetLvl | input | 1 | System reset level, 1 = released |
| pfoLvl | input | 1 | Power-fail output level |
| mrLvl | input | 1 | Manual reset level |
| selBattery | output | 1 | Supply select, 1 = battery |
| battOn | output | 1 | Rail fed from the battery |
| measEn | output | 1 | Battery measurement window enable |
| battOk | output | 1 | Latched battery health verdict |

## Verification
The assertions assume the comparator flags are already synchronous to `clk` and stay constant between edges. The bench therefore changes every input only 1 ns after a rising edge and holds it for whole cycles.

The properties also assume that `resetLvl` reflects the supervisor's reset output. Because of this, the stimulus raises it only after the main-supply flags are good again. The one exception is the seal sequence, where `pfoLvl` and `mrLvl` are pulled low on purpose.

// File: rtl/supply_sw_pkg.sv
package supply_sw_pkg;

  // Strobes handed from the control FSM to the measurement datapath.
  typedef struct packed {
    logic runActive;   // reset released and sampled: timers may run
  } ctlStrobe_t;

endpackage

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import supply_sw_pkg::*;
(
  input  logic       clk,
  input  logic       rstAsyncN,
  input  logic       mainAboveSw,
  input  logic       mainAboveBat,
  input  logic       outBelowSwn,
  input  logic       mainAboveSwp,
  input  logic       manSwitch,
  input  logic       resetLvl,
  input  logic       pfoLvl,
  input  logic       mrLvl,
  output logic       onBat,
  output logic       sealActive,
  output ctlStrobe_t strobe
);

  logic onBatQ, sealQ, mainGoodQ, resetPrevQ, runQ;
  logic sealArm, resetRise, sealNext, onBatNext;

  // Seal arms when the main supply drops with both pins held low.
  assign sealArm   = mainGoodQ & ~mainAboveSw & ~pfoLvl & ~mrLvl;
  assign resetRise = resetLvl & ~resetPrevQ;

  always_comb begin
    if (resetRise)    sealNext = 1'b0;
    else if (sealArm) sealNext = 1'b1;
    else              sealNext = sealQ;
  end

  // Source selection: seal beats manual, manual beats automatic rules.
  always_comb begin
    if (sealNext)       onBatNext = 1'b0;
    else if (manSwitch) onBatNext = 1'b1;
    else if (onBatQ)    onBatNext = ~(mainAboveBat | mainAboveSwp);
    else                onBatNext = outBelowSwn & ~mainAboveBat;
  end

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      onBatQ     <= 1'b0;
      sealQ      <= 1'b0;
      mainGoodQ  <= 1'b0;
      resetPrevQ <= 1'b0;
      runQ       <= 1'b0;
    end else begin
      onBatQ     <= onBatNext;
      sealQ      <= sealNext;
      mainGoodQ  <= mainAboveSw;
      resetPrevQ <= resetLvl;
      runQ       <= resetLvl;
    end
  end

  assign onBat            = onBatQ;
  assign sealActive       = sealQ;
  assign strobe.runActive = runQ;

endmodule

// File: rtl/sw_datapath.sv
module sw_datapath
  import supply_sw_pkg::*;
#(
  parameter int PERIOD_CYC = 40_000_000,
  parameter int MEAS_CYC   = 5_000
) (
  input  logic       clk,
  input  logic       rstAsyncN,
  input  ctlStrobe_t strobe,
  input  logic       batAboveOk,
  output logic       measEn,
  output logic       battOk
);

  localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] PERIOD_LAST = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] MEAS_LAST   = CNT_W'(MEAS_CYC - 1);
  localparam logic [CNT_W-1:0] MEAS_LEN    = CNT_W'(MEAS_CYC);

  logic [CNT_W-1:0] periodCnt;
  logic             inWindow;

  generate
    if (MEAS_CYC >= PERIOD_CYC) begin : g_always_window
      assign inWindow = 1'b1;
    end else begin : g_part_window
      assign inWindow = periodCnt < MEAS_LEN;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      periodCnt <= '0;
    end else if (!strobe.runActive) begin
      periodCnt <= '0;
    end else if (periodCnt == PERIOD_LAST) begin
      periodCnt <= '0;
    end else begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      battOk <= 1'b1;
    end else if (strobe.runActive && periodCnt == MEAS_LAST) begin
      battOk <= batAboveOk;
    end
  end

  assign measEn = strobe.runActive & inWindow;

endmodule

// File: rtl/supply_switchover.sv
module supply_switchover
  import supply_sw_pkg::*;
#(
  parameter int PERIOD_CYC = 40_000_000,
  parameter int MEAS_CYC   = 5_000
) (
  input  logic clk,
  input  logic rstAsyncN,
  input  logic mainAboveSw,
  input  logic mainAboveBat,
  input  logic outBelowSwn,
  input  logic mainAboveSwp,
  input  logic batAboveOk,
  input  logic manSwitch,
  input  logic resetLvl,
  input  logic pfoLvl,
  input  logic mrLvl,
  output logic selBattery,
  output logic battOn,
  output logic measEn,
  output logic battOk
);

  ctlStrobe_t strobe;
  logic       onBat;
  logic       sealActive;

  sw_ctrl ctrl_i (
    .clk          (clk),
    .rstAsyncN    (rstAsyncN),
    .mainAboveSw  (mainAboveSw),
    .mainAboveBat (mainAboveBat),
    .outBelowSwn  (outBelowSwn),
    .mainAboveSwp (mainAboveSwp),
    .manSwitch    (manSwitch),
    .resetLvl     (resetLvl),
    .pfoLvl       (pfoLvl),
    .mrLvl        (mrLvl),
    .onBat        (onBat),
    .sealActive   (sealActive),
    .strobe       (strobe)
  );

  sw_datapath #(
    .PERIOD_CYC (PERIOD_CYC),
    .MEAS_CYC   (MEAS_CYC)
  ) dp_i (
    .clk        (clk),
    .rstAsyncN  (rstAsyncN),
    .strobe     (strobe),
    .batAboveOk (batAboveOk),
    .measEn     (measEn),
    .battOk     (battOk)
  );

  assign selBattery = onBat;
  assign battOn     = onBat;

endmodule

// File: rtl/supply_switchover_chk.sv
module supply_switchover_chk (
  input logic clk,
  input logic rstAsyncN,
  input logic mainAboveBat,
  input logic outBelowSwn,
  input logic mainAboveSwp,
  input logic manSwitch,
  input logic resetLvl,
  input logic battOn,
  input logic measEn,
  input logic battOk,
  input logic sealActive
);

  // R2: a fresh battery selection needs a sag with the battery above main, or manual request
  a_r2_entry_cause: assert property (@(posedge clk) disable iff (!rstAsyncN)
    $rose(battOn) |-> ($past(manSwitch) || ($past(outBelowSwn) && !$past(mainAboveBat))));

  // R3: either return condition ends battery operation
  a_r3_return_first: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (battOn && !manSwitch && !sealActive && (mainAboveBat || mainAboveSwp)) |=> !battOn);

  // R4: manual request selects the battery unless a seal takes over
  a_r4_manual_force: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (manSwitch && !sealActive) |=> (battOn || sealActive));

  // R7: battery never feeds the rail while sealed
  a_r7_seal_blocks: assert property (@(posedge clk) disable iff (!rstAsyncN)
    sealActive |-> !battOn);

  // R8: a measurement window only follows a released reset
  a_r8_window_after_release: assert property (@(posedge clk) disable iff (!rstAsyncN)
    measEn |-> $past(resetLvl));

  // R9: outside the window the verdict holds
  a_r9_verdict_holds: assert property (@(posedge clk) disable iff (!rstAsyncN)
    !measEn |=> $stable(battOk));

endmodule

bind supply_switchover supply_switchover_chk chk_i (
  .clk          (clk),
  .rstAsyncN    (rstAsyncN),
  .mainAboveBat (mainAboveBat),
  .outBelowSwn  (outBelowSwn),
  .mainAboveSwp (mainAboveSwp),
  .manSwitch    (manSwitch),
  .resetLvl     (resetLvl),
  .battOn       (battOn),
  .measEn       (measEn),
  .battOk       (battOk),
  .sealActive   (sealActive)
);

// File: tb/supply_switchover_tb_top.sv
`timescale 1ns/1ps
module supply_switchover_tb_top;

  localparam int PERIOD = 40;
  localparam int MEAS   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mainAboveSw = 1'b1, mainAboveBat = 1'b1, outBelowSwn = 1'b0;
  logic mainAboveSwp = 1'b1, batAboveOk = 1'b1, manSwitch = 1'b0;
  logic resetLvl = 1'b0, pfoLvl = 1'b1, mrLvl = 1'b1;
  logic selBattery, battOn, measEn, battOk;

  always #2.5 clk = ~clk;

  supply_switchover #(.PERIOD_CYC(PERIOD), .MEAS_CYC(MEAS)) dut_i (
    .clk(clk), .rstAsyncN(rstN),
    .mainAboveSw(mainAboveSw), .mainAboveBat(mainAboveBat),
    .outBelowSwn(outBelowSwn), .mainAboveSwp(mainAboveSwp),
    .batAboveOk(batAboveOk), .manSwitch(manSwitch), .resetLvl(resetLvl),
    .pfoLvl(pfoLvl), .mrLvl(mrLvl),
    .selBattery(selBattery), .battOn(battOn), .measEn(measEn), .battOk(battOk)
  );

  // Behavioural reference model
  bit mBat, mSeal, mMainPrev, mRstPrev, mRun, mOk;
  int mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBat = 0; mSeal = 0; mMainPrev = 0; mRstPrev = 0; mRun = 0; mOk = 1; mCnt = 0;
    end else begin
      bit seal, bat;
      seal = mSeal;
      if (mMainPrev && !mainAboveSw && !pfoLvl && !mrLvl) seal = 1;
      if (resetLvl && !mRstPrev) seal = 0;
      if (seal) bat = 0;
      else if (manSwitch) bat = 1;
      else if (mBat) bat = !(mainAboveBat || mainAboveSwp);
      else bat = outBelowSwn && !mainAboveBat;
      if (mRun && mCnt == MEAS - 1) mOk = batAboveOk;
      if (!mRun) mCnt = 0; else mCnt = (mCnt + 1) % PERIOD;
      mBat = bat; mSeal = seal; mMainPrev = mainAboveSw;
      mRstPrev = resetLvl; mRun = resetLvl;
    end
  end

  int nVec = 0, nBad = 0;
  bit finished = 0;
  string phase = "R1";

  task automatic check1(string tag, string what, logic act, bit exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareNow();
    check1(phase, "battOn", battOn, mBat);
    check1("R5", "selBattery==battOn", selBattery, battOn);
    check1((phase == "R1") ? "R1" : "R8", "measEn", measEn, mRun && (mCnt < MEAS));
    check1((phase == "R1") ? "R1" : "R9", "battOk", battOk, mOk);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      compareNow();
    end
  endtask

  initial begin
    // R1: during and just after power-on clear
    #1; compareNow();
    cyc(3);
    rstN = 1'b1;
    cyc(4);
    // R8 / R9: release reset, windows with good battery then weak battery
    phase = "R8"; resetLvl = 1'b1;
    cyc(90);
    phase = "R9"; batAboveOk = 1'b0;
    cyc(90);
    batAboveOk = 1'b1;
    cyc(50);
    // R2: sag while main still above battery -> stay on main
    phase = "R2";
    mainAboveSwp = 1'b0; mainAboveSw = 1'b0; outBelowSwn = 1'b1;
    cyc(5);
    mainAboveBat = 1'b0;   // battery now higher -> switch
    cyc(5);
    // R3: return because main rises above battery
    phase = "R3"; mainAboveBat = 1'b1;
    cyc(4);
    mainAboveBat = 1'b0;
    cyc(4);
    mainAboveSwp = 1'b1;   // return via positive threshold
    cyc(4);
    mainAboveSwp = 1'b0; outBelowSwn = 1'b0;
    cyc(3);
    // R4: manual request with main healthy
    phase = "R4"; mainAboveSw = 1'b1; mainAboveBat = 1'b1; mainAboveSwp = 1'b1;
    cyc(3);
    manSwitch = 1'b1;
    cyc(5);
    manSwitch = 1'b0;
    cyc(4);
    // R6: arm seal: main good, pins low, main drops
    phase = "R6"; pfoLvl = 1'b0; mrLvl = 1'b0;
    cyc(3);
    mainAboveSw = 1'b0; mainAboveSwp = 1'b0; resetLvl = 1'b0;
    cyc(2);
    pfoLvl = 1'b1; mrLvl = 1'b1;
    // R7: sealed -> no battery despite sag and manual request
    phase = "R7"; mainAboveBat = 1'b0; outBelowSwn = 1'b1; manSwitch = 1'b1;
    cyc(10);
    // R7: reset rising edge clears seal
    mainAboveSw = 1'b1; resetLvl = 1'b1;
    cyc(10);
    manSwitch = 1'b0; mainAboveSwp = 1'b1;
    cyc(60);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule